// File: doc/BRIEF.md
# Stop-Mode Wake Source Recorder

This block notes which wake sources brought the device out of its most recent low-power STOP period. Six single-cycle strobes come in: keyboard, external interrupt pin, temperature restart, periodic wakeup timer, low-frequency receiver and RF module. Strobes seen while STOP is active are collected. When STOP ends, the collected set replaces the whole flag image at once. The flags therefore always describe the latest exit only. Software does not clear them one by one.

The image is an 8-bit read-only status register served on a simple read strobe. The two top bits are reserved and always read zero. A write strobe is present on the bus but has no effect on the register.

Top module: `wake_src_rec`

## Requirements
- R1: The flag bits are laid out as follows: bit 0 is the RF module, bit 1 the low-frequency receiver, bit 2 the periodic wakeup timer, bit 3 temperature restart, bit 4 the external interrupt pin and bit 5 the keyboard.
- R2: A STOP exit is the first cycle in which `stop_active` is low after a cycle in which it was high. On the clock edge that closes that cycle, all six flags are replaced by the set of sources that strobed on edges where `stop_active` was high during that STOP period. Flags for sources that did not strobe are cleared.
- R3: Several sources strobing in the same cycle, including the last cycle of STOP, each set their own flag.
- R4: Strobes sampled while `stop_active` is low, including in the exit cycle itself, change neither the register nor the next capture.
- R5: Bits 7 and 6 of `rd_data` always read 0.
- R6: Between STOP exits the flags hold their value.
- R7: After reset all flags read 0.
- R8: A write (`wr_en` high with any `wr_data`) has no effect on the register.
- R9: When `rd_en` is high in a cycle, `rd_data` shows the register image as it was in that cycle, from the next edge onward. Otherwise `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_active | input | 1 | High while the device is in STOP |
| wake_kbd | input | 1 | Keyboard wake strobe |
| wake_irq | input | 1 | External interrupt pin wake strobe |
| wake_temp | input | 1 | Temperature restart wake strobe |
| wake_tmr | input | 1 | Periodic wakeup timer strobe |
| wake_lf | input | 1 | Low-frequency receiver wake strobe |
| wake_rf | input | 1 | RF module wake strobe |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe (ignored) |
| wr_data | input | 8 | Write data (ignored) |
| rd_data | output | 8 | Read data, registered |

## Verification
A wrong collected set shows up on the first read after the next STOP exit. Because of the read register, it appears one cycle after that read. A flag that fails to clear, or a stale source carried over from an earlier period, looks just like a missed replacement. For that reason the bench runs back-to-back STOP periods with disjoint sources. Strobes that leak in outside STOP stay hidden until the following exit. Reads are therefore taken after every exit, not only after the period in which the leak happened.

// File: rtl/wake_src_rec.sv
module wake_src_rec #(
  parameter int NSRC  = 6,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_active,
  input  logic             wake_kbd,
  input  logic             wake_irq,
  input  logic             wake_temp,
  input  logic             wake_tmr,
  input  logic             wake_lf,
  input  logic             wake_rf,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);
  localparam int RESV_W = REG_W - NSRC;

  logic [NSRC-1:0] ev, acc, flags;
  logic            stop_q, stop_exit;
  logic            unused_wr;

  assign ev        = {wake_kbd, wake_irq, wake_temp, wake_tmr, wake_lf, wake_rf};
  assign stop_exit = stop_q & ~stop_active;
  assign unused_wr = wr_en ^ (^wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      acc    <= '0;
      flags  <= '0;
    end else begin
      stop_q <= stop_active;
      if (stop_exit) begin
        flags <= acc;
        acc   <= '0;
      end else if (stop_active) begin
        acc <= acc | ev;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= {{RESV_W{1'b0}}, flags};
  end
endmodule

module wake_src_rec_chk #(
  parameter int NSRC  = 6,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_active,
  input logic             rd_en,
  input logic             wr_en,
  input logic [NSRC-1:0]  flags,
  input logic [NSRC-1:0]  acc,
  input logic [REG_W-1:0] rd_data
);
  logic seen_stop;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_stop <= 1'b0;
    else        seen_stop <= stop_active;

  wire ext = seen_stop & ~stop_active;

  p_resv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:NSRC] == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext |=> $stable(flags));

  p_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ext) |=> $stable(flags));

  p_exit_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ext |=> (flags == $past(acc)) && (acc == '0));

  p_read_image_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data[NSRC-1:0] == $past(flags));

  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind wake_src_rec wake_src_rec_chk #(.NSRC(NSRC), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_active(stop_active), .rd_en(rd_en),
  .wr_en(wr_en), .flags(flags), .acc(acc), .rd_data(rd_data)
);

// File: tb/tb_wake_src_rec.sv
`timescale 1ns/1ps
module tb_wake_src_rec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_active = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [5:0] ev = '0;
  logic [7:0] wr_data = '0, rd_data;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  wake_src_rec dut (
    .clk(clk), .rst_n(rst_n), .stop_active(stop_active),
    .wake_kbd(ev[5]), .wake_irq(ev[4]), .wake_temp(ev[3]),
    .wake_tmr(ev[2]), .wake_lf(ev[1]), .wake_rf(ev[0]),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  logic       m_stop_q = 1'b0;
  logic [5:0] m_acc = '0, m_flags = '0;
  logic [7:0] m_rd = '0;

  function automatic logic [7:0] image(input logic [5:0] f);
    return {2'b00, f};
  endfunction

  task automatic check(input string req);
    tests++;
    if (rd_data !== m_rd) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, m_rd);
    end
  endtask

  task automatic cyc(input logic s, input logic [5:0] e, input logic rd,
                     input logic wr, input logic [7:0] wd, input string req);
    stop_active = s; ev = e; rd_en = rd; wr_en = wr; wr_data = wd;
    @(posedge clk);
    if (rd) m_rd = image(m_flags);
    if (m_stop_q && !s) begin m_flags = m_acc; m_acc = '0; end
    else if (s) m_acc = m_acc | e;
    m_stop_q = s;
    @(negedge clk);
    check(req);
  endtask

  task automatic read(input string req);
    cyc(1'b0, 6'h00, 1'b1, 1'b0, 8'h00, req);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: expected=done actual=hung");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (rd_data !== 8'h00) begin fails++; $display("FAIL R7: rd_data=%h expected=00", rd_data); end
    read("R7");
    // R1: each source alone maps to its own bit
    for (int b = 0; b < 6; b++) begin
      cyc(1'b1, 6'h00, 1'b0, 1'b0, 8'h00, "R1");
      cyc(1'b1, 6'(1 << b), 1'b0, 1'b0, 8'h00, "R1");
      cyc(1'b0, 6'h00, 1'b0, 1'b0, 8'h00, "R1");
      read("R1");
      tests++;
      if (rd_data !== 8'(1 << b)) begin fails++; $display("FAIL R1: rd_data=%h expected=%h", rd_data, 8'(1 << b)); end
    end
    // R3: simultaneous in the final STOP cycle
    cyc(1'b1, 6'h00, 1'b0, 1'b0, 8'h00, "R3");
    cyc(1'b1, 6'h2A, 1'b0, 1'b0, 8'h00, "R3");
    cyc(1'b0, 6'h00, 1'b0, 1'b0, 8'h00, "R3");
    read("R3");
    // R2: next period with disjoint sources replaces old flags
    cyc(1'b1, 6'h01, 1'b0, 1'b0, 8'h00, "R2");
    cyc(1'b1, 6'h04, 1'b0, 1'b0, 8'h00, "R2");
    cyc(1'b0, 6'h00, 1'b0, 1'b0, 8'h00, "R2");
    read("R2");
    // R4: strobes outside STOP and in the exit cycle
    cyc(1'b0, 6'h3F, 1'b0, 1'b0, 8'h00, "R4");
    read("R4");
    cyc(1'b1, 6'h10, 1'b0, 1'b0, 8'h00, "R4");
    cyc(1'b0, 6'h2F, 1'b0, 1'b0, 8'h00, "R4");
    read("R4");
    // R8: writes ignored
    cyc(1'b0, 6'h00, 1'b0, 1'b1, 8'hFF, "R8");
    read("R8");
    // R2: empty STOP period clears all flags
    cyc(1'b1, 6'h00, 1'b0, 1'b0, 8'h00, "R2");
    cyc(1'b0, 6'h00, 1'b0, 1'b0, 8'h00, "R2");
    read("R2");
    // R9: read during exit returns the pre-exit image
    cyc(1'b1, 6'h08, 1'b0, 1'b0, 8'h00, "R9");
    cyc(1'b0, 6'h00, 1'b1, 1'b0, 8'h00, "R9");
    read("R9");
    // R5 R6 random mix
    for (int i = 0; i < 3000; i++) begin
      logic s;
      logic [5:0] e;
      s = ($urandom_range(0, 3) != 0) ? m_stop_q : ~m_stop_q;
      e = ($urandom_range(0, 2) == 0) ? 6'($urandom) : 6'h00;
      cyc(s, e, 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 4) == 0),
          8'($urandom), "R6");
      tests++;
      if (rd_data[7:6] !== 2'b00) begin fails++; $display("FAIL R5: rd_data=%h expected=00xxxxxx", rd_data); end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule